// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit performs one of four operations on a single selected bit of an operand: test, change (invert), clear and set. The operand is either a full 32-bit register word or an 8-bit memory byte carried in the low lane of the operand port. The bit number comes from one of two inputs, a register value or an immediate field, and a per-operation select chooses between them. In every case the zero flag is loaded with the inverse of the selected bit as it stood before the operation. Only then is the bit left alone, inverted, cleared or set.

A caller presents the operand, the two bit-number sources, the operation and the incoming condition flags, and pulses `in_valid`. One clock later the unit presents the updated operand and the flags with only the zero position replaced. It also raises `out_valid` and, for the three modifying operations, raises a write-enable so that the caller can store the result. The unit does not compute addresses, run bus cycles or decode instructions.

Top module: `bit_modify_unit`

## Requirements
- R1: `out_flags[2]` (the zero position) equals the inverse of the selected operand bit as it was before the operation, for every operation.
- R2: Operation code 2'b00 (test) returns the operand unchanged and does not raise `out_we`.
- R3: Operation code 2'b01 (change) inverts the selected bit and leaves every other bit as it was.
- R4: Operation code 2'b10 (clear) forces the selected bit to 0 and leaves every other bit as it was.
- R5: Operation code 2'b11 (set) forces the selected bit to 1 and leaves every other bit as it was.
- R6: `use_imm` = 0 takes the bit number from `reg_num`, and `use_imm` = 1 takes it from `imm_num`.
- R7: When `is_byte` = 0, the bit number is taken modulo 32, so only its low 5 bits count.
- R8: When `is_byte` = 1, the bit number is taken modulo 8, so only its low 3 bits count, and operand bits 31:8 pass through unchanged.
- R9: Every flag bit of the 5-bit `flags_in` other than bit 2 reaches `out_flags` unchanged.
- R10: `out_we` is high only in an `out_valid` cycle, and only for change, clear or set.
- R11: The results and `out_valid` appear on the clock edge after the one that sampled `in_valid`. Without a strobe, `out_valid` is low and the result outputs hold their values. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Strobe: sample the inputs on this edge |
| operand | input | 32 | Register word, or a byte in bits 7:0 |
| reg_num | input | 8 | Bit number taken from a register |
| imm_num | input | 8 | Bit number taken from an immediate field |
| use_imm | input | 1 | 1 selects `imm_num`, 0 selects `reg_num` |
| op | input | 2 | 00 test, 01 change, 10 clear, 11 set |
| is_byte | input | 1 | 1 for a byte operand, 0 for a 32-bit register |
| flags_in | input | 5 | Incoming condition flags, zero flag at bit 2 |
| out_valid | output | 1 | Result valid this cycle |
| out_operand | output | 32 | Updated operand |
| out_flags | output | 5 | Flags with bit 2 replaced by the zero result |
| out_we | output | 1 | Write the result back |

## Verification
A wrong bit index, for example one that ignores the byte modulo or reads the wrong source, shows on the port one cycle after the strobe in two ways. The changed bit lands at the wrong position in `out_operand`, and the zero flag disagrees with the bit that actually moved. A corrupted mask is also visible at that cycle, because more than one bit then differs from the input operand. A lost flag pass-through or a stray write-enable is caught at the same cycle. A result register that fails to hold shows in the idle cycle that follows.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

   typedef enum logic [1:0] {
      BOP_TEST  = 2'b00,
      BOP_FLIP  = 2'b01,
      BOP_CLEAR = 2'b10,
      BOP_SET   = 2'b11
   } bit_op_e;

   function automatic logic op_writes(input bit_op_e op);
      return op != BOP_TEST;
   endfunction

endpackage

// File: rtl/bmu_index_sel.sv
module bmu_index_sel #(
   parameter int NUM_W  = 8,
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   localparam int IDX_W  = $clog2(DATA_W),
   localparam int BIDX_W = $clog2(BYTE_W)
) (
   input  logic [NUM_W-1:0] reg_num,
   input  logic [NUM_W-1:0] imm_num,
   input  logic             use_imm,
   input  logic             is_byte,
   output logic [IDX_W-1:0] idx
);

   logic [NUM_W-1:0] raw;

   always_comb begin
      raw = use_imm ? imm_num : reg_num;
      if (is_byte) idx = IDX_W'(raw[BIDX_W-1:0]);
      else         idx = raw[IDX_W-1:0];
   end

endmodule

// File: rtl/bmu_mask_dec.sv
module bmu_mask_dec #(
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] mask
);

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_lane
      assign mask[gi] = (idx == IDX_W'(gi));
   end

endmodule

// File: rtl/bmu_bit_alu.sv
module bmu_bit_alu
   import bmu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] mask,
   input  bit_op_e           op,
   output logic [DATA_W-1:0] result,
   output logic              zero,
   output logic              write_req
);

   always_comb begin
      zero      = ~|(operand & mask);
      write_req = op_writes(op);
      unique case (op)
         BOP_TEST:  result = operand;
         BOP_FLIP:  result = operand ^ mask;
         BOP_CLEAR: result = operand & ~mask;
         BOP_SET:   result = operand | mask;
         default:   result = operand;
      endcase
   end

endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
   import bmu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int NUM_W    = 8,
   parameter int FLAG_W   = 5,
   parameter int ZERO_POS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] operand,
   input  logic [NUM_W-1:0]  reg_num,
   input  logic [NUM_W-1:0]  imm_num,
   input  logic              use_imm,
   input  logic [1:0]        op,
   input  logic              is_byte,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_operand,
   output logic [FLAG_W-1:0] out_flags,
   output logic              out_we
);

   localparam int IDX_W = $clog2(DATA_W);

   if ((1 << IDX_W) != DATA_W) begin : g_bad_data_w
      $error("DATA_W must be a power of two");
   end
   if (BYTE_W > DATA_W || (1 << $clog2(BYTE_W)) != BYTE_W) begin : g_bad_byte_w
      $error("BYTE_W must be a power of two no wider than DATA_W");
   end
   if (NUM_W < IDX_W) begin : g_bad_num_w
      $error("NUM_W too narrow for DATA_W");
   end
   if (ZERO_POS >= FLAG_W) begin : g_bad_zero_pos
      $error("ZERO_POS outside the flag vector");
   end

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] result;
   logic              zero;
   logic              write_req;
   logic [FLAG_W-1:0] flags_next;

   bmu_index_sel #(
      .NUM_W (NUM_W),
      .DATA_W(DATA_W),
      .BYTE_W(BYTE_W)
   ) i_index_sel (
      .reg_num(reg_num),
      .imm_num(imm_num),
      .use_imm(use_imm),
      .is_byte(is_byte),
      .idx    (idx)
   );

   bmu_mask_dec #(
      .DATA_W(DATA_W)
   ) i_mask_dec (
      .idx (idx),
      .mask(mask)
   );

   bmu_bit_alu #(
      .DATA_W(DATA_W)
   ) i_bit_alu (
      .operand  (operand),
      .mask     (mask),
      .op       (bit_op_e'(op)),
      .result   (result),
      .zero     (zero),
      .write_req(write_req)
   );

   for (genvar gf = 0; gf < FLAG_W; gf++) begin : g_flag
      if (gf == ZERO_POS) begin : g_zero
         assign flags_next[gf] = zero;
      end else begin : g_pass
         assign flags_next[gf] = flags_in[gf];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_we      <= 1'b0;
         out_operand <= '0;
         out_flags   <= '0;
      end else begin
         out_valid <= in_valid;
         out_we    <= in_valid & write_req;
         if (in_valid) begin
            out_operand <= result;
            out_flags   <= flags_next;
         end
      end
   end

endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
   parameter int DATA_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int FLAG_W   = 5,
   parameter int ZERO_POS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] operand,
   input logic [1:0]        op,
   input logic              is_byte,
   input logic [FLAG_W-1:0] flags_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_operand,
   input logic [FLAG_W-1:0] out_flags,
   input logic              out_we
);

   localparam logic [FLAG_W-1:0] ZMASK = FLAG_W'(1) << ZERO_POS;

   // R1 with R4: a clear left the word unchanged exactly when the bit was 0
   a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == 2'b10 |=> out_flags[ZERO_POS] == (out_operand == $past(operand)));

   // R1 with R5: a set left the word unchanged exactly when the bit was 1
   a_r1_set_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == 2'b11 |=> out_flags[ZERO_POS] == (out_operand != $past(operand)));

   a_r2_test_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == 2'b00 |=> out_operand == $past(operand) && !out_we);

   a_r3_flip_moves_one: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == 2'b01 |=> $countones(out_operand ^ $past(operand)) == 1);

   a_r4_r5_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> $countones(out_operand ^ $past(operand)) <= 1);

   a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && is_byte |=>
         out_operand[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W]));

   a_r9_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_flags & ~ZMASK) == ($past(flags_in) & ~ZMASK));

   a_r10_we_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_we |-> out_valid);

   a_r10_we_modify: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op != 2'b00 |=> out_we);

   a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_operand) && $stable(out_flags));

endmodule

bind bit_modify_unit bmu_checker #(
   .DATA_W  (DATA_W),
   .BYTE_W  (BYTE_W),
   .FLAG_W  (FLAG_W),
   .ZERO_POS(ZERO_POS)
) i_bmu_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .operand    (operand),
   .op         (op),
   .is_byte    (is_byte),
   .flags_in   (flags_in),
   .out_valid  (out_valid),
   .out_operand(out_operand),
   .out_flags  (out_flags),
   .out_we     (out_we)
);

// File: tb/test_bit_modify_unit.sv
module test_bit_modify_unit;

   typedef struct packed {
      logic [1:0]  op;
      logic        byt;
      logic        imm;
      logic [7:0]  rnum;
      logic [7:0]  inum;
      logic [4:0]  flg;
      logic [31:0] opnd;
      logic [31:0] exp_opnd;
      logic        exp_z;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      // R2 R6: test, register number 5
      '{2'b00, 1'b0, 1'b0, 8'd5,    8'd3,    5'b11111, 32'h0000_0020, 32'h0000_0020, 1'b0},
      // R6: immediate number 3 chosen over register number 5
      '{2'b00, 1'b0, 1'b1, 8'd5,    8'd3,    5'b00000, 32'h0000_0020, 32'h0000_0020, 1'b1},
      // R3: change bit 31
      '{2'b01, 1'b0, 1'b0, 8'd31,   8'd0,    5'b10101, 32'h0000_0000, 32'h8000_0000, 1'b1},
      // R3 R7: 36 mod 32 = 4
      '{2'b01, 1'b0, 1'b0, 8'd36,   8'd9,    5'b01010, 32'hFFFF_FFFF, 32'hFFFF_FFEF, 1'b0},
      // R4: clear bit 0 from immediate
      '{2'b10, 1'b0, 1'b1, 8'd7,    8'd0,    5'b11011, 32'h0000_0001, 32'h0000_0000, 1'b0},
      // R4: clear an already clear bit
      '{2'b10, 1'b0, 1'b0, 8'd10,   8'd1,    5'b00100, 32'h0000_0000, 32'h0000_0000, 1'b1},
      // R5: set bit 16
      '{2'b11, 1'b0, 1'b0, 8'd16,   8'd2,    5'b11111, 32'h1234_0000, 32'h1235_0000, 1'b1},
      // R5 R7: 63 mod 32 = 31, already set
      '{2'b11, 1'b0, 1'b1, 8'd0,    8'd63,   5'b00001, 32'h8000_0000, 32'h8000_0000, 1'b0},
      // R8 R3: byte, 11 mod 8 = 3
      '{2'b01, 1'b1, 1'b0, 8'd11,   8'd0,    5'b10000, 32'hAABB_CC00, 32'hAABB_CC08, 1'b1},
      // R8 R5: byte, 15 mod 8 = 7
      '{2'b11, 1'b1, 1'b1, 8'd0,    8'd15,   5'b01110, 32'hFFFF_FF00, 32'hFFFF_FF80, 1'b1},
      // R8 R4: byte, 31 mod 8 = 7
      '{2'b10, 1'b1, 1'b0, 8'd31,   8'd4,    5'b11111, 32'h0000_00FF, 32'h0000_007F, 1'b0},
      // R8 R2: byte, 9 mod 8 = 1
      '{2'b00, 1'b1, 1'b1, 8'd200,  8'd9,    5'b00011, 32'h0000_0002, 32'h0000_0002, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] operand = '0;
   logic [7:0]  reg_num = '0;
   logic [7:0]  imm_num = '0;
   logic        use_imm = 1'b0;
   logic [1:0]  op = '0;
   logic        is_byte = 1'b0;
   logic [4:0]  flags_in = '0;
   logic        out_valid;
   logic [31:0] out_operand;
   logic [4:0]  out_flags;
   logic        out_we;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bit_modify_unit i_bit_modify_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .operand    (operand),
      .reg_num    (reg_num),
      .imm_num    (imm_num),
      .use_imm    (use_imm),
      .op         (op),
      .is_byte    (is_byte),
      .flags_in   (flags_in),
      .out_valid  (out_valid),
      .out_operand(out_operand),
      .out_flags  (out_flags),
      .out_we     (out_we)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      in_valid = 1'b1;
      op       = v.op;
      is_byte  = v.byt;
      use_imm  = v.imm;
      reg_num  = v.rnum;
      imm_num  = v.inum;
      flags_in = v.flg;
      operand  = v.opnd;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [4:0]  exp_f;
      logic [31:0] held;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      check({31'd0, out_valid}, 32'd0, "R11 reset out_valid");
      check(out_operand, 32'd0, "R11 reset out_operand");
      check({27'd0, out_flags}, 32'd0, "R11 reset out_flags");
      check({31'd0, out_we}, 32'd0, "R11 reset out_we");

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(posedge clk);
         #1;
         exp_f = (VECS[i].flg & ~5'b00100) | {2'b00, VECS[i].exp_z, 2'b00};
         check({31'd0, out_valid}, 32'd1, "R11 out_valid after strobe");
         check(out_operand, VECS[i].exp_opnd, "R2-R8 table operand");
         check({31'd0, out_flags[2]}, {31'd0, VECS[i].exp_z}, "R1 zero flag");
         check({27'd0, out_flags}, {27'd0, exp_f}, "R9 flag pass-through");
         check({31'd0, out_we}, {31'd0, VECS[i].op != 2'b00}, "R10 write enable");
      end

      // R11: idle cycle holds results with changed inputs
      held = out_operand;
      @(negedge clk);
      in_valid = 1'b0;
      operand  = 32'hDEAD_BEEF;
      op       = 2'b11;
      flags_in = 5'b10101;
      @(posedge clk);
      #1;
      check({31'd0, out_valid}, 32'd0, "R11 idle out_valid low");
      check(out_operand, held, "R11 idle operand held");
      check({31'd0, out_we}, 32'd0, "R10 idle no write enable");

      // R3: back-to-back strobes, second result follows one cycle later
      drive('{2'b01, 1'b0, 1'b0, 8'd0, 8'd0, 5'b00000, 32'h0000_0001, 32'h0, 1'b0});
      @(posedge clk);
      #1;
      check(out_operand, 32'h0000_0000, "R3 back-to-back first");
      check({31'd0, out_flags[2]}, 32'd0, "R1 back-to-back first zero");
      drive('{2'b01, 1'b0, 1'b0, 8'd0, 8'd0, 5'b00000, 32'h0000_0000, 32'h0, 1'b0});
      @(posedge clk);
      #1;
      check(out_operand, 32'h0000_0001, "R3 back-to-back second");
      check({31'd0, out_flags[2]}, 32'd1, "R1 back-to-back second zero");
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      #1;
      check({31'd0, out_valid}, 32'd0, "R11 valid drops");

      // R11: reset clears outputs again
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check(out_operand, 32'd0, "R11 reset clears operand");
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule